// File: doc/BRIEF.md
# Per-Pin Programmable Interrupt Sense Detector

This block watches a set of external interrupt request pins, eight by default. For each pin it raises a request bit according to a 2-bit sense code that the pin has to itself. A pin can be set to request while its input is held low, or to latch a request on a falling edge, on a rising edge, or on either edge. Every pin input passes through a two-stage synchroniser. An edge is found by comparing the synchronised level with its value one clock earlier.

The sense codes sit in a configuration register. Two copies of that register exist, one for each of two requesting agents, and software must keep them equal. The copy with index 0 drives detection. A select line chooses which copy a write or a read reaches, and a registered mismatch flag warns when the two copies differ. In the edge modes a request stays set until software writes 1 to that pin's bit of a clear strobe. Changing a pin's sense code drops that pin's pending request. Priority, masking and vectoring belong to the logic downstream.

Top module: `irq_sense_detector`

## Requirements
- R1: A synchronous reset sets both register copies, `reg_rdata`, `irq_req` and `copy_mismatch` to 0, and loads the synchroniser with 1s so that no request or edge comes from reset.
- R2: Pin n is governed by bits [2n+1:2n] of copy 0. The contents of copy 1 never affect detection.
- R3: Sense code 00 (low level) drives `irq_req[n]` high while the synchronised pin is low. It is not latched. A pin change applied before clock edge k shows on `irq_req` after edge k+2.
- R4: Sense code 01 sets the request of pin n on a falling edge of the synchronised pin, visible after edge k+2.
- R5: Sense code 10 sets the request on a rising edge of the synchronised pin.
- R6: Sense code 11 sets the request on either edge of the synchronised pin.
- R7: In the edge modes the request stays set until a cycle in which `flag_clr[n]` is 1. A new edge in that same cycle wins over the clear. In low-level mode `flag_clr` has no effect.
- R8: If a write to copy 0 changes pin n's sense code, the request of pin n is 0 after that edge, and any edge detected in that cycle is dropped. A write that leaves the code unchanged keeps the request.
- R9: A write updates only the copy chosen by `reg_sel` (0 or 1). `reg_rdata` is loaded each cycle from the copy chosen by `reg_sel`.
- R10: `copy_mismatch` is 1 one cycle after the stored copies differ, and 0 one cycle after they are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous interrupt request pins |
| reg_wr_en | input | 1 | Write strobe for the selected copy |
| reg_sel | input | 1 | Copy select for reads and writes |
| reg_wdata | input | 2*NUM_PINS | Write data, 2 bits per pin |
| reg_rdata | output | 2*NUM_PINS | Registered contents of the selected copy |
| flag_clr | input | NUM_PINS | Write-1-to-clear strobe for the edge requests |
| irq_req | output | NUM_PINS | Registered request per pin |
| copy_mismatch | output | 1 | Registered flag, copies differ |

## Verification
On every cycle the assertions check the following. Low-level requests follow the pin three cycles later. Edge requests stay set until cleared. A sense-code change leaves the pin with no request. Readback and the mismatch flag track a shadow of both copies. Only the bench's scenarios show that each of the four codes actually raises the request on the right transition. The same holds for the set-over-clear priority in one cycle, for copy 1 having no influence on detection, and for the exact latency of an edge. A directed sequence and a cycle model driven by seeded random pins, clears and writes cover these.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int SENSE_W = 2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_pin_sync.sv
// Multi-stage synchroniser plus a one-cycle-delayed copy for edge compare.
module irq_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
      prev_q <= '1;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/irq_sense_regs.sv
// Two copies of the sense configuration, readback and mismatch flag.
module irq_sense_regs
  import irq_sense_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_i,
  input  logic                        sel_i,
  input  logic [NUM_PINS*SENSE_W-1:0] wdata_i,
  output logic [NUM_PINS*SENSE_W-1:0] rdata_o,
  output logic                        mismatch_o,
  output logic [NUM_PINS*SENSE_W-1:0] active_cfg_o,
  output logic [NUM_PINS-1:0]         cfg_change_o
);
  localparam int CFG_W      = NUM_PINS * SENSE_W;
  localparam int NUM_COPIES = 2;

  logic [CFG_W-1:0] copy_q [NUM_COPIES];
  logic [CFG_W-1:0] rdata_q;
  logic             mismatch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_COPIES; c++) copy_q[c] <= '0;
      rdata_q    <= '0;
      mismatch_q <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_COPIES; c++)
        if (wr_en_i && (int'(sel_i) == c)) copy_q[c] <= wdata_i;
      rdata_q    <= copy_q[sel_i];
      mismatch_q <= (copy_q[0] != copy_q[1]);
    end
  end

  // Per-pin change detect on writes to the active copy.
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chg
    assign cfg_change_o[n] = wr_en_i && !sel_i &&
        (wdata_i[n*SENSE_W +: SENSE_W] != copy_q[0][n*SENSE_W +: SENSE_W]);
  end

  assign rdata_o      = rdata_q;
  assign mismatch_o   = mismatch_q;
  assign active_cfg_o = copy_q[0];
endmodule

// File: rtl/irq_sense_cell.sv
// One pin: edge classify and the request register.
module irq_sense_cell
  import irq_sense_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  sense_e mode_i,
  input  logic   sync_i,
  input  logic   prev_i,
  input  logic   clr_i,
  input  logic   chg_i,
  output logic   req_o
);
  logic rise, fall, hit;
  logic req_q;

  always_comb begin
    rise = sync_i & ~prev_i;
    fall = ~sync_i & prev_i;
    unique case (mode_i)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                    req_q <= 1'b0;
    else if (chg_i)             req_q <= 1'b0;
    else if (mode_i == SENSE_LOW) req_q <= ~sync_i;
    else                        req_q <= hit | (req_q & ~clr_i);
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_sense_detector.sv
module irq_sense_detector
  import irq_sense_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PINS-1:0]         pin_in,
  input  logic                        reg_wr_en,
  input  logic                        reg_sel,
  input  logic [NUM_PINS*SENSE_W-1:0] reg_wdata,
  output logic [NUM_PINS*SENSE_W-1:0] reg_rdata,
  input  logic [NUM_PINS-1:0]         flag_clr,
  output logic [NUM_PINS-1:0]         irq_req,
  output logic                        copy_mismatch
);
  localparam int CFG_W = NUM_PINS * SENSE_W;

  logic [NUM_PINS-1:0] pin_sync, pin_prev, cfg_change;
  logic [CFG_W-1:0]    active_cfg;

  irq_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_in), .sync_o(pin_sync), .prev_o(pin_prev)
  );

  irq_sense_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(reg_wr_en), .sel_i(reg_sel), .wdata_i(reg_wdata),
    .rdata_o(reg_rdata), .mismatch_o(copy_mismatch), .active_cfg_o(active_cfg),
    .cfg_change_o(cfg_change)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    irq_sense_cell u_cell (
      .clk(clk), .rst(rst),
      .mode_i(sense_e'(active_cfg[n*SENSE_W +: SENSE_W])),
      .sync_i(pin_sync[n]), .prev_i(pin_prev[n]),
      .clr_i(flag_clr[n]), .chg_i(cfg_change[n]),
      .req_o(irq_req[n])
    );
  end
endmodule

// File: rtl/irq_sense_chk.sv
module irq_sense_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PINS-1:0]   pin_in,
  input logic                  reg_wr_en,
  input logic                  reg_sel,
  input logic [2*NUM_PINS-1:0] reg_wdata,
  input logic [2*NUM_PINS-1:0] reg_rdata,
  input logic [NUM_PINS-1:0]   flag_clr,
  input logic [NUM_PINS-1:0]   irq_req,
  input logic                  copy_mismatch
);
  logic [2*NUM_PINS-1:0] sh0, sh1;
  logic [2:0]            cyc;
  logic [NUM_PINS-1:0]   chg, lvl_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh0 <= '0; sh1 <= '0; cyc <= '0;
    end else begin
      if (reg_wr_en && !reg_sel) sh0 <= reg_wdata;
      if (reg_wr_en &&  reg_sel) sh1 <= reg_wdata;
      if (cyc != 3'd7) cyc <= cyc + 3'd1;
    end
  end

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_req == '0 && reg_rdata == '0 && !copy_mismatch));

  // R9: readback of the selected copy
  p_readback_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2) |-> (reg_rdata == $past(reg_sel ? sh1 : sh0)));

  // R10: mismatch flag
  p_mismatch_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2) |-> (copy_mismatch == $past(sh0 != sh1)));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign chg[n]    = reg_wr_en && !reg_sel && (reg_wdata[2*n +: 2] != sh0[2*n +: 2]);
    assign lvl_ok[n] = (sh0[2*n +: 2] == 2'b00) && !chg[n];

    // R7: edge request is sticky until cleared
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 3'd1 && sh0[2*n +: 2] != 2'b00 && irq_req[n] && !flag_clr[n] && !chg[n])
      |=> irq_req[n]);

    // R8: sense-code change drops the request
    p_change_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 3'd1 && chg[n]) |=> !irq_req[n]);

    // R3: low level follows the pin three cycles later
    p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
      (cyc >= 3'd4 && $past(lvl_ok[n])) |-> (irq_req[n] == !$past(pin_in[n], 3)));
  end
endmodule

bind irq_sense_detector irq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .pin_in(pin_in), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_clr(flag_clr),
  .irq_req(irq_req), .copy_mismatch(copy_mismatch)
);

// File: tb/tb_irq_sense_detector.sv
module tb_irq_sense_detector;
  localparam int NP = 8;
  localparam int CW = 2 * NP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pin_in = '1;
  logic reg_wr_en = 1'b0, reg_sel = 1'b0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic [NP-1:0] flag_clr = '0;
  logic [NP-1:0] irq_req;
  logic copy_mismatch;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_sense_detector #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_clr(flag_clr),
    .irq_req(irq_req), .copy_mismatch(copy_mismatch)
  );

  // Cycle model built from the requirements
  logic [NP-1:0] m_s1, m_s2, m_p, m_req;
  logic [CW-1:0] m_c0, m_c1, m_rd;
  logic          m_mm;

  function automatic logic next_req(input logic [1:0] md, input logic s, input logic p,
                                    input logic q, input logic clr, input logic chg);
    logic hit;
    if (chg) return 1'b0;
    if (md == 2'b00) return ~s;
    hit = (md[0] && !s && p) || (md[1] && s && !p);
    return hit | (q & ~clr);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '1; m_s2 <= '1; m_p <= '1; m_req <= '0;
      m_c0 <= '0; m_c1 <= '0; m_rd <= '0; m_mm <= 1'b0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1; m_p <= m_s2;
      for (int n = 0; n < NP; n++)
        m_req[n] <= next_req(m_c0[2*n +: 2], m_s2[n], m_p[n], m_req[n], flag_clr[n],
                     reg_wr_en && !reg_sel && (reg_wdata[2*n +: 2] != m_c0[2*n +: 2]));
      if (reg_wr_en && !reg_sel) m_c0 <= reg_wdata;
      if (reg_wr_en &&  reg_sel) m_c1 <= reg_wdata;
      m_rd <= reg_sel ? m_c1 : m_c0;
      m_mm <= (m_c0 != m_c1);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [CW-1:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
    tick();
    reg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq_req), 32'h0);
    check("R1 rdata", 32'(reg_rdata), 32'h0);
    check("R1 mismatch", 32'(copy_mismatch), 32'h0);

    // pins 0..3: low, fall, rise, both
    wr(1'b0, 16'h00E4);
    tick();
    check("R10 mismatch set", 32'(copy_mismatch), 32'h1);
    wr(1'b1, 16'h00E4);
    tick();
    check("R9 readback copy1", 32'(reg_rdata), 32'h00E4);
    check("R10 mismatch clear", 32'(copy_mismatch), 32'h0);

    pin_in = 8'hF0;
    tick(); tick();
    check("R3 latency before", 32'(irq_req), 32'h00);
    tick();
    check("R3 R4 R6 low", 32'(irq_req), 32'h0B);
    pin_in = 8'hFF;
    repeat (3) tick();
    check("R5 R6 R7 high", 32'(irq_req), 32'h0E);
    flag_clr = 8'h0F;
    tick();
    flag_clr = 8'h00;
    check("R7 clear", 32'(irq_req), 32'h00);

    pin_in = 8'hF0;
    repeat (3) tick();
    check("R3 R4 R6 again", 32'(irq_req), 32'h0B);
    wr(1'b0, 16'h00EC);  // pin1 code 01 -> 11
    check("R8 change clears", 32'(irq_req), 32'h09);
    flag_clr = 8'h01;
    tick();
    flag_clr = 8'h00;
    check("R7 level ignores clear", 32'(irq_req), 32'h09);
    check("R10 mismatch after copy0", 32'(copy_mismatch), 32'h1);
    wr(1'b1, 16'hFFFF);
    pin_in = 8'hE0;
    repeat (3) tick();
    check("R2 copy0 governs", 32'(irq_req), 32'h19);
    wr(1'b1, 16'h00EC);
    pin_in = 8'hFF;
    repeat (3) tick();

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < NP; b++)
        if ($urandom % 6 == 0) pin_in[b] = ~pin_in[b];
      flag_clr  = ($urandom % 4 == 0) ? NP'($urandom) : '0;
      reg_sel   = 1'($urandom);
      reg_wr_en = ($urandom % 12 == 0);
      reg_wdata = CW'($urandom);
      tick();
      check("R2/R3/R4/R5/R6/R7/R8 irq", 32'(irq_req), 32'(m_req));
      check("R9 rdata", 32'(reg_rdata), 32'(m_rd));
      check("R10 mismatch", 32'(copy_mismatch), 32'(m_mm));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule